// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor word port and a lower memory that delivers whole lines. It holds 1024 sets of two ways. Each way keeps a valid flag, an 18-bit tag and a 16-byte line. On each request the set index reads both ways at once. Their tags are compared side by side, and the word of whichever way matches is steered to the processor. This happens in the same cycle the request is presented.

On a read miss, the controller picks a victim way. It fills an empty way if the set has one, and otherwise uses a per-set recency bit. It then asks the lower memory for the line-aligned block that holds the requested address and accepts four words in ascending order. Once the line is written into the victim way, the held request hits and completes. Writes always go to lower memory. A write that hits also updates the cached word. A write that misses leaves the cache untouched. The processor port keeps ready low while a refill or a write is outstanding.

Top module: `cache2w_top`

## Requirements
- R1: The address splits into tag = bits 31:14, set index = bits 13:4, word select = bits 3:2; byte bits 1:0 are ignored. Reset clears every valid flag, so the first read of any line after reset misses.
- R2: A read that hits raises cpu_ready in the same cycle as the request and returns the 32-bit word stored for that address on cpu_rdata. It makes no lower-memory request, and at most one way matches.
- R3: A read miss produces exactly one single-cycle mem_rd_req. mem_addr carries the line-aligned address, with bits 3:0 equal to zero. The next four mem_rd_valid beats are taken as words 0,1,2,3 of the line, and word k sits at byte offset 4k.
- R4: From the miss until the fourth beat is written, cpu_ready stays low. The held read then completes with the word from the newly filled line.
- R5: The refill goes to way 0 if it is invalid, otherwise to way 1 if it is invalid. Otherwise it goes to the way named by the set's recency bit.
- R6: Every read hit, write hit and refill sets the recency bit of that set to point at the way not just used.
- R7: A write raises mem_wr_req with mem_addr equal to the request address with bits 1:0 cleared, and mem_wdata equal to cpu_wdata. Both are held until mem_wr_ack. cpu_ready rises in the cycle of mem_wr_ack.
- R8: A write that hits replaces the cached word, so a later read of that address hits and returns the written value.
- R9: A write that misses allocates no line, so a later read of that address misses.
- R10: Two lines with the same index and different tags can be resident at once. A third line with that index evicts the less recently used one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready on reads |
| mem_rd_req | output | 1 | One-cycle line fetch request |
| mem_wr_req | output | 1 | Word write request, held until ack |
| mem_addr | output | 32 | Line address for fetches, word address for writes |
| mem_wdata | output | 32 | Word written through to lower memory |
| mem_rd_valid | input | 1 | One refill word is present on mem_rdata |
| mem_rdata | input | 32 | Refill word |
| mem_wr_ack | input | 1 | Lower memory accepted the write |

## Verification
The assertions watch, on every cycle, the rules that hold locally:
- at most one way matches;
- a line fetch is aligned;
- a refill always returns control to lookup;
- a write never allocates;
- the recency bit moves away from the way just used;
- ready never rises on a read without a hit, or during a refill.

Whether the right word lands at the right offset, whether the victim choice follows recency across a sequence of conflicting lines, and whether a write hit or miss changes later lookups can only be shown by the bench. It does this by running directed conflict sequences and random traffic over a few sets against its own model of memory and set occupancy.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 10;
    localparam int OFF_W      = 4;
    localparam int WAYS       = 2;
    localparam int BSEL_W     = $clog2(WORD_W / 8);
    localparam int WSEL_W     = OFF_W - BSEL_W;
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_WORDS = 2 ** WSEL_W;
    localparam int LINE_W     = LINE_WORDS * WORD_W;
    localparam int SETS       = 2 ** IDX_W;
    localparam int WAY_W      = $clog2(WAYS);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic [BSEL_W-1:0] bsel;
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RREQ  = 2'd1,
        ST_FILL  = 2'd2,
        ST_WRITE = 2'd3
    } state_e;

    function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] tag,
                                                    input logic [IDX_W-1:0] idx);
        return {tag, idx, {OFF_W{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] word_base(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}};
    endfunction

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way
    import cache2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [WSEL_W-1:0] lk_wsel,
    output logic              lk_valid,
    output logic              lk_hit,
    output logic [WORD_W-1:0] lk_word,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              upd_we,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [WSEL_W-1:0] upd_wsel,
    input  logic [WORD_W-1:0] upd_word
);

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_we) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[fill_idx]  <= fill_tag;
            line_q[fill_idx] <= fill_line;
        end else if (upd_we) begin
            line_q[upd_idx][upd_wsel*WORD_W +: WORD_W] <= upd_word;
        end
    end

    always_comb begin
        lk_valid = valid_q[lk_idx];
        lk_hit   = lk_valid && (tag_q[lk_idx] == lk_tag);
        lk_word  = line_q[lk_idx][lk_wsel*WORD_W +: WORD_W];
    end

    AST_NO_FILL_ON_WORD_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !(fill_we && upd_we)); // R9

    AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> valid_q[$past(fill_idx)]); // R1

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru
    import cache2w_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0] victim,
    input  logic             use_en,
    input  logic [IDX_W-1:0] use_idx,
    input  logic [WAY_W-1:0] use_way
);

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (use_en) begin
            lru_q[use_idx] <= ~use_way;
        end
    end

    always_comb begin
        if (!way_valid[0]) begin
            victim = 1'b0;
        end else if (!way_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru_q[rd_idx];
        end
    end

    AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (rst)
        use_en |=> (lru_q[$past(use_idx)] != $past(use_way))); // R6

    AST_EMPTY_WAY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (way_valid != 2'b11) |-> !way_valid[victim]); // R5

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic              hit,
    input  logic [WAY_W-1:0]  hit_way,
    input  logic [WAY_W-1:0]  victim,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_wr_ack,
    output logic              cpu_ready,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [TAG_W-1:0]  miss_tag,
    output logic [IDX_W-1:0]  miss_idx,
    output logic              fill_we,
    output logic [WAY_W-1:0]  fill_way,
    output logic [LINE_W-1:0] fill_line,
    output logic              word_we,
    output logic              lru_use_en,
    output logic [IDX_W-1:0]  lru_use_idx,
    output logic [WAY_W-1:0]  lru_use_way
);

    state_e            state_q;
    logic [WSEL_W-1:0] beat_q;
    logic [WORD_W-1:0] buf_q [LINE_WORDS-1];
    logic [TAG_W-1:0]  miss_tag_q;
    logic [IDX_W-1:0]  miss_idx_q;
    logic [WAY_W-1:0]  victim_q;
    logic              rd_hit_done;
    logic              last_beat;

    always_comb begin
        rd_hit_done = (state_q == ST_IDLE) && cpu_req && !cpu_we && hit;
        last_beat   = (state_q == ST_FILL) && mem_rd_valid
                      && (beat_q == WSEL_W'(LINE_WORDS - 1));
        word_we     = (state_q == ST_WRITE) && mem_wr_ack && hit;
        cpu_ready   = rd_hit_done || ((state_q == ST_WRITE) && mem_wr_ack);
        mem_rd_req  = (state_q == ST_RREQ);
        mem_wr_req  = (state_q == ST_WRITE);
        fill_we     = last_beat;
        fill_way    = victim_q;
        miss_tag    = miss_tag_q;
        miss_idx    = miss_idx_q;
        lru_use_en  = rd_hit_done || word_we || last_beat;
        lru_use_idx = last_beat ? miss_idx_q : lk_idx;
        lru_use_way = last_beat ? victim_q : hit_way;
    end

    for (genvar k = 0; k < LINE_WORDS; k++) begin : g_line
        if (k == LINE_WORDS - 1) begin : g_last
            assign fill_line[k*WORD_W +: WORD_W] = mem_rdata;
        end else begin : g_held
            assign fill_line[k*WORD_W +: WORD_W] = buf_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            beat_q     <= '0;
            miss_tag_q <= '0;
            miss_idx_q <= '0;
            victim_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req && cpu_we) begin
                        state_q <= ST_WRITE;
                    end else if (cpu_req && !hit) begin
                        state_q    <= ST_RREQ;
                        miss_tag_q <= lk_tag;
                        miss_idx_q <= lk_idx;
                        victim_q   <= victim;
                    end
                end
                ST_RREQ: begin
                    state_q <= ST_FILL;
                    beat_q  <= '0;
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ack) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LINE_WORDS - 1; k++) begin
            if ((state_q == ST_FILL) && mem_rd_valid && (beat_q == WSEL_W'(k))) begin
                buf_q[k] <= mem_rdata;
            end
        end
    end

    AST_READY_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && !cpu_we) |-> hit); // R2

    AST_STALL_WHILE_FILLING: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RREQ) || (state_q == ST_FILL)) |-> !cpu_ready); // R4

    AST_FILL_BACK_TO_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> (state_q == ST_IDLE)); // R3

    AST_WRITE_NO_ALLOCATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |-> !fill_we); // R9

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        mem_rd_req,
    output logic        mem_wr_req,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rdata,
    input  logic        mem_wr_ack
);

    addr_t             a;
    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   way_hit;
    logic [WORD_W-1:0] way_word [WAYS];
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic [TAG_W-1:0]  miss_tag;
    logic [IDX_W-1:0]  miss_idx;
    logic              fill_we;
    logic [WAY_W-1:0]  fill_way;
    logic [LINE_W-1:0] fill_line;
    logic              word_we;
    logic              lru_use_en;
    logic [IDX_W-1:0]  lru_use_idx;
    logic [WAY_W-1:0]  lru_use_way;

    assign a = addr_t'(cpu_addr);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache2w_way u_way (
            .clk       (clk),
            .rst       (rst),
            .lk_idx    (a.idx),
            .lk_tag    (a.tag),
            .lk_wsel   (a.wsel),
            .lk_valid  (way_valid[w]),
            .lk_hit    (way_hit[w]),
            .lk_word   (way_word[w]),
            .fill_we   (fill_we && (fill_way == WAY_W'(w))),
            .fill_idx  (miss_idx),
            .fill_tag  (miss_tag),
            .fill_line (fill_line),
            .upd_we    (word_we && way_hit[w]),
            .upd_idx   (a.idx),
            .upd_wsel  (a.wsel),
            .upd_word  (cpu_wdata)
        );
    end

    always_comb begin
        hit       = |way_hit;
        hit_way   = '0;
        cpu_rdata = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                hit_way   = WAY_W'(w);
                cpu_rdata = cpu_rdata | way_word[w];
            end
        end
    end

    cache2w_lru u_lru (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (a.idx),
        .way_valid (way_valid),
        .victim    (victim),
        .use_en    (lru_use_en),
        .use_idx   (lru_use_idx),
        .use_way   (lru_use_way)
    );

    cache2w_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .lk_tag       (a.tag),
        .lk_idx       (a.idx),
        .hit          (hit),
        .hit_way      (hit_way),
        .victim       (victim),
        .mem_rd_valid (mem_rd_valid),
        .mem_rdata    (mem_rdata),
        .mem_wr_ack   (mem_wr_ack),
        .cpu_ready    (cpu_ready),
        .mem_rd_req   (mem_rd_req),
        .mem_wr_req   (mem_wr_req),
        .miss_tag     (miss_tag),
        .miss_idx     (miss_idx),
        .fill_we      (fill_we),
        .fill_way     (fill_way),
        .fill_line    (fill_line),
        .word_we      (word_we),
        .lru_use_en   (lru_use_en),
        .lru_use_idx  (lru_use_idx),
        .lru_use_way  (lru_use_way)
    );

    assign mem_addr  = mem_rd_req ? line_base(miss_tag, miss_idx) : word_base(cpu_addr);
    assign mem_wdata = cpu_wdata;

    AST_LINE_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (mem_addr[OFF_W-1:0] == '0)); // R3

    AST_SINGLE_WAY_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit)); // R2

    AST_WRITE_HELD_TO_ACK: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_wr_ack) |=> mem_wr_req); // R7

    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req); // R3

endmodule

// File: tb/cache2w_tb_top.sv
module cache2w_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_rd_req;
    logic        mem_wr_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_wr_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] mem_m [int unsigned];
    bit          mv  [1024][2];
    logic [17:0] mt  [1024][2];
    bit          ml  [1024];

    always #10 clk = ~clk;

    cache2w_top dut_i (
        .clk (clk), .rst (rst), .cpu_req (cpu_req), .cpu_we (cpu_we),
        .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata), .mem_rd_req (mem_rd_req), .mem_wr_req (mem_wr_req),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rd_valid (mem_rd_valid),
        .mem_rdata (mem_rdata), .mem_wr_ack (mem_wr_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_read(input logic [31:0] wa);
        if (mem_m.exists(wa)) return mem_m[wa];
        return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic int model_way(input logic [31:0] addr);
        for (int w = 0; w < 2; w++)
            if (mv[addr[13:4]][w] && mt[addr[13:4]][w] == addr[31:14]) return w;
        return -1;
    endfunction

    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd);
        int          hw;
        int          vic;
        int          cycles;
        int          rd_seen;
        int          wr_seen;
        int          beats_left;
        int          beats_done;
        int          wr_wait;
        bit          wr_pend;
        bit          done;
        logic [31:0] line;
        logic [31:0] wr_addr;
        logic [31:0] wr_data;
        logic [31:0] got;
        logic [31:0] exp_data;
        logic [9:0]  ix;
        ix = addr[13:4];
        hw = model_way(addr);
        exp_data = we ? wd : mem_read({addr[31:2], 2'b00});
        cycles = 0; rd_seen = 0; wr_seen = 0; beats_left = 0; beats_done = 0;
        wr_wait = 0; wr_pend = 0; done = 0; line = '0; wr_addr = '0; wr_data = '0; got = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        while (!done && cycles < 300) begin
            if (cycles > 0) @(negedge clk);
            mem_rd_valid = 1'b0;
            mem_wr_ack = 1'b0;
            if (beats_left > 0 && ($urandom % 3 != 0)) begin
                mem_rdata = mem_read(line + 32'(4 * beats_done));
                mem_rd_valid = 1'b1;
                beats_done++;
                beats_left--;
            end
            if (wr_pend) begin
                if (wr_wait == 0) begin
                    mem_wr_ack = 1'b1;
                    mem_m[wr_addr] = wr_data;
                    wr_pend = 1'b0;
                end else begin
                    wr_wait--;
                end
            end
            #1;
            if (mem_rd_req) begin
                rd_seen++;
                line = mem_addr;
                beats_left = 4;
                check(mem_addr == {addr[31:4], 4'h0}, "R3", "line fetch address",
                      mem_addr, {addr[31:4], 4'h0});
            end
            if (mem_wr_req && !wr_pend && !mem_wr_ack) begin
                wr_seen++;
                wr_pend = 1'b1;
                wr_wait = $urandom % 3;
                wr_addr = mem_addr;
                wr_data = mem_wdata;
            end
            if (cpu_ready) begin
                done = 1'b1;
                got = cpu_rdata;
            end
            cycles++;
        end
        check(done, "R4", "request completed", 32'(done), 32'd1);
        if (we) begin
            // R7: word address and data go through; R8/R9 checked by later reads
            check(wr_seen == 1, "R7", "write request count", 32'(wr_seen), 32'd1);
            check(wr_addr == {addr[31:2], 2'b00}, "R7", "write address", wr_addr, {addr[31:2], 2'b00});
            check(wr_data == wd, "R7", "write data", wr_data, wd);
            check(rd_seen == 0, "R9", "no fetch on write", 32'(rd_seen), 32'd0);
            if (hw >= 0) ml[ix] = (hw == 0);
        end else begin
            check(got == exp_data, hw >= 0 ? "R2" : "R4", "read data", got, exp_data);
            if (hw >= 0) begin
                check(rd_seen == 0, "R2", "fetches on hit", 32'(rd_seen), 32'd0);
                check(cycles == 1, "R2", "hit latency", 32'(cycles), 32'd1);
                ml[ix] = (hw == 0);
            end else begin
                check(rd_seen == 1, "R10", "fetches on miss", 32'(rd_seen), 32'd1);
                check(beats_done == 4, "R4", "beats before ready", 32'(beats_done), 32'd4);
                vic = !mv[ix][0] ? 0 : (!mv[ix][1] ? 1 : int'(ml[ix]));
                mv[ix][vic] = 1'b1;
                mt[ix][vic] = addr[31:14];
                ml[ix] = (vic == 0);
            end
        end
        @(negedge clk);
        cpu_req = 1'b0;
        mem_rd_valid = 1'b0;
        mem_wr_ack = 1'b0;
    endtask

    function automatic logic [31:0] mk(input int tag, input int idx, input int w);
        return {18'(tag), 10'(idx), 2'(w), 2'b00};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!cpu_ready, "R1", "ready after reset", 32'(cpu_ready), 32'd0);
        check(!mem_rd_req && !mem_wr_req, "R1", "memory idle after reset",
              32'({mem_rd_req, mem_wr_req}), 32'd0);
        // R1: cold miss; R3: line refill word placement across all offsets
        access(1'b0, mk(1, 5, 2), 32'h0);
        for (int w = 0; w < 4; w++) access(1'b0, mk(1, 5, w), 32'h0);
        // R5: second tag fills the empty way; R10: both resident
        access(1'b0, mk(2, 5, 1), 32'h0);
        access(1'b0, mk(1, 5, 3), 32'h0);
        access(1'b0, mk(2, 5, 0), 32'h0);
        // R6/R10: tag 1 used last before this? tag 2 was; third tag evicts tag 1
        access(1'b0, mk(3, 5, 0), 32'h0);
        access(1'b0, mk(2, 5, 2), 32'h0);
        access(1'b0, mk(1, 5, 2), 32'h0);
        // R8: write hit then read hit returns new value
        access(1'b1, mk(1, 5, 2), 32'hCAFE_F00D);
        access(1'b0, mk(1, 5, 2), 32'h0);
        // R9: write miss, then read misses and returns written value
        access(1'b1, mk(7, 9, 1), 32'h1234_5678);
        access(1'b0, mk(7, 9, 1), 32'h0);
        // R1: byte bits ignored
        access(1'b0, mk(7, 9, 1) | 32'h3, 32'h0);
        for (int i = 0; i < 400; i++) begin
            access(($urandom % 4) == 0,
                   mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4)),
                   $urandom);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule